// File: doc/BRIEF.md
# Reloadable Down-Counting Event Timer

The block is a 32-bit timer that sits on a simple word-addressed register bus. The bus has a write strobe, an address, write data and registered read data. Software programs it through four registers:

- a control word holding a run bit and an interrupt mask bit;
- a live count that can be written directly;
- a reload value;
- an event register that shows and clears a pending flag.

While running, the count drops by one on every clock. When the count is at zero on a running clock, it takes the reload value instead and flags an event. A level interrupt line reports that flag whenever the mask bit allows it.

The same registers cover the two usual ways of using a timer. For a periodic or free-running time base, load count and reload with the same value and let the count wrap; reading the count and inverting its bits gives a rising timestamp. For a single delay, write the count directly and run with the interrupt enabled. After the event, clear it and stop the timer. Writing zero to both control and reload shuts the timer down completely.

Top module: `cdt_timer`

## Requirements
- R1: After synchronous reset, control, count, reload and the pending flag are all zero, and irq_o is low. Every register reads back zero.
- R2: The control register is at offset 0x0. Bit 0 is the run bit and bit 3 is the interrupt mask bit. Every other control bit is ignored on write and reads as zero.
- R3: The count register is at offset 0x4. When the run bit is set and the count is not zero, the count decreases by exactly one per clock. When the run bit is clear, the count holds its value.
- R4: The reload register is at offset 0x8 and reads back what was last written to it. A write to the count register loads the written value on that clock edge, taking precedence over counting and reloading.
- R5: On a clock where the run bit is set, the count is zero and the count is not being written, the count takes the reload value and the pending flag sets. This happens whatever the mask bit is.
- R6: irq_o is a register output. On each clock edge it takes the AND of the pending flag and mask bit 3 from before that edge.
- R7: The event register is at offset 0xC and reads back the pending flag in bit 0, with all other bits zero. Writing 1 to bit 0 clears the flag. Writing 0 to bit 0 leaves the flag unchanged.
- R8: If a clear write to the event register and a zero-reach event happen on the same clock, the pending flag remains set.
- R9: Any address other than the four register offsets reads as zero. Writes to such an address change no register.
- R10: With the reload value at 0xFFFFFFFF and only the run bit set, the count wraps from zero to 0xFFFFFFFF and keeps counting down, and irq_o stays low.
- R11: bus_rdata shows the addressed register as it was just before the rising clock edge that sampled bus_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | AW (8) | Byte offset of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data for the previous address |
| irq_o | output | 1 | Level interrupt, pending flag gated by mask bit |

## Verification
The hardest situation to reach from the ports is the same-clock collision between a clear write and a zero-reach event (R8). Making it happen needs the count to be exactly zero with the run bit set on the very clock the clear is issued. The directed stimulus gets there by writing zero into the count while the timer runs, then issuing the clear on the next clock. Random stimulus keeps count and reload values small, so zero-reach events happen often, and it mixes in clear writes so that further collisions occur by chance. The wrap case (R10) is reached by loading a small count with an all-ones reload rather than waiting out the full 32-bit range.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // Register offsets (byte addresses on a word-addressed bus)
  localparam int unsigned OFF_CTRL = 'h0;
  localparam int unsigned OFF_CNT  = 'h4;
  localparam int unsigned OFF_RLD  = 'h8;
  localparam int unsigned OFF_EVT  = 'hC;
  // Control bit positions
  localparam int unsigned RUN_BIT  = 0;
  localparam int unsigned MASK_BIT = 3;
  // Event register bit position
  localparam int unsigned PEND_BIT = 0;
endpackage

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic [DW-1:0] reload_val,
  output logic [DW-1:0] count,
  output logic          zero_evt
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] cnt_q;

  assign zero_evt = run && !load && (cnt_q == '0);
  assign count    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (zero_evt) begin
      cnt_q <= reload_val;
    end else if (run) begin
      cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic mask_en,
  output logic pend,
  output logic irq
);
  logic pend_q;
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      // a new event takes precedence over a clear on the same clock
      if (set) begin
        pend_q <= 1'b1;
      end else if (clr) begin
        pend_q <= 1'b0;
      end
      irq_q <= pend_q && mask_en;
    end
  end

  assign pend = pend_q;
  assign irq  = irq_q;
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);
  localparam logic [AW-1:0] A_CTRL = AW'(OFF_CTRL);
  localparam logic [AW-1:0] A_CNT  = AW'(OFF_CNT);
  localparam logic [AW-1:0] A_RLD  = AW'(OFF_RLD);
  localparam logic [AW-1:0] A_EVT  = AW'(OFF_EVT);

  logic          hit_ctrl, hit_cnt, hit_rld, hit_evt;
  logic          run_q, mask_q;
  logic [DW-1:0] rld_q;
  logic [DW-1:0] cnt_q;
  logic          evt;
  logic          pend_q;
  logic          clr_req;
  logic [DW-1:0] rd_next;
  logic [DW-1:0] rdata_q;

  assign hit_ctrl = (bus_addr == A_CTRL);
  assign hit_cnt  = (bus_addr == A_CNT);
  assign hit_rld  = (bus_addr == A_RLD);
  assign hit_evt  = (bus_addr == A_EVT);

  // control and reload registers
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      mask_q <= 1'b0;
      rld_q  <= '0;
    end else if (bus_we) begin
      if (hit_ctrl) begin
        run_q  <= bus_wdata[RUN_BIT];
        mask_q <= bus_wdata[MASK_BIT];
      end
      if (hit_rld) begin
        rld_q <= bus_wdata;
      end
    end
  end

  cdt_counter #(.DW(DW)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .run        (run_q),
    .load       (bus_we && hit_cnt),
    .load_val   (bus_wdata),
    .reload_val (rld_q),
    .count      (cnt_q),
    .zero_evt   (evt)
  );

  assign clr_req = bus_we && hit_evt && bus_wdata[PEND_BIT];

  cdt_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .set     (evt),
    .clr     (clr_req),
    .mask_en (mask_q),
    .pend    (pend_q),
    .irq     (irq_o)
  );

  // read multiplexer, registered
  always_comb begin
    rd_next = '0;
    if (hit_ctrl) begin
      rd_next[RUN_BIT]  = run_q;
      rd_next[MASK_BIT] = mask_q;
    end else if (hit_cnt) begin
      rd_next = cnt_q;
    end else if (hit_rld) begin
      rd_next = rld_q;
    end else if (hit_evt) begin
      rd_next[PEND_BIT] = pend_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_next;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk
  import cdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] count,
  input logic [DW-1:0] reload,
  input logic          run,
  input logic          mask_en,
  input logic          pend,
  input logic          irq_o
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic cnt_wr, clr_wr, at_zero;
  assign cnt_wr  = bus_we && (bus_addr == AW'(OFF_CNT));
  assign clr_wr  = bus_we && (bus_addr == AW'(OFF_EVT)) && bus_wdata[PEND_BIT];
  assign at_zero = run && !cnt_wr && (count == '0);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (count == '0 && reload == '0 && !run && !mask_en && !pend && !irq_o));

  a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
    (run && !cnt_wr && count != '0) |=> (count == $past(count) - ONE));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(count));

  a_r4_direct_load: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (count == $past(bus_wdata)));

  a_r5_reload_event: assert property (@(posedge clk) disable iff (rst)
    at_zero |=> (count == $past(reload) && pend));

  a_r6_masked_low: assert property (@(posedge clk) disable iff (rst)
    !mask_en |=> !irq_o);

  a_r6_follows_pend: assert property (@(posedge clk) disable iff (rst)
    (pend && mask_en) |=> irq_o);

  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !at_zero) |=> !pend);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && at_zero) |=> pend);
endmodule

bind cdt_timer cdt_timer_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .count     (cnt_q),
  .reload    (rld_q),
  .run       (run_q),
  .mask_en   (mask_q),
  .pend      (pend_q),
  .irq_o     (irq_o)
);

// File: tb/tb_cdt_timer.sv
module tb_cdt_timer;
  localparam int DW = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_o;

  int n_chk = 0;
  int n_fail = 0;

  // reference state from the requirements
  logic          m_run, m_mask, m_pend, m_irq;
  logic [DW-1:0] m_cnt, m_rld, m_rdata;
  string         tag_rd, tag_irq;

  always #10 clk = ~clk;

  cdt_timer #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic string rd_tag(input logic [AW-1:0] a);
    case (a)
      8'h00:   return "R2";
      8'h04:   return "R3";
      8'h08:   return "R4";
      8'h0C:   return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [DW-1:0] m_read(input logic [AW-1:0] a);
    case (a)
      8'h00:   return {28'b0, m_mask, 2'b00, m_run};
      8'h04:   return m_cnt;
      8'h08:   return m_rld;
      8'h0C:   return {31'b0, m_pend};
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    m_run = 0; m_mask = 0; m_pend = 0; m_irq = 0;
    m_cnt = '0; m_rld = '0; m_rdata = '0;
  endtask

  // one bus cycle: check outputs of the previous cycle, drive, advance model
  task automatic cyc(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input string tag);
    logic          ev, cwr, clr;
    logic [DW-1:0] rd_n;
    logic          irq_n;
    check(tag_rd, bus_rdata, m_rdata);
    check(tag_irq, {31'b0, irq_o}, {31'b0, m_irq});
    bus_we = we; bus_addr = a; bus_wdata = d;
    cwr   = we && a == 8'h04;
    clr   = we && a == 8'h0C && d[0];
    ev    = m_run && !cwr && m_cnt == '0;
    rd_n  = m_read(a);
    irq_n = m_pend && m_mask;
    if (cwr) m_cnt = d;
    else if (ev) m_cnt = m_rld;
    else if (m_run) m_cnt = m_cnt - 1;
    if (ev) m_pend = 1'b1;
    else if (clr) m_pend = 1'b0;
    if (we && a == 8'h00) begin m_run = d[0]; m_mask = d[3]; end
    if (we && a == 8'h08) m_rld = d;
    m_rdata = rd_n;
    m_irq   = irq_n;
    tag_rd  = (tag == "") ? rd_tag(a) : tag;
    tag_irq = (tag == "") ? "R6" : tag;
    @(posedge clk);
    #5;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    cyc(1'b0, a, '0, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    cyc(1'b1, a, d, tag);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    m_reset();
    tag_rd = "R1"; tag_irq = "R1";
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    rst = 1'b0;
    // R1: reset state on every register and irq_o
    rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h08, "R1"); rd(8'h0C, "R1"); rd(8'h00, "R1");

    // R2: only bits 0 and 3 stick
    wr(8'h00, 32'hFFFF_FFF6, "R2"); rd(8'h00, "R2");
    wr(8'h00, 32'hFFFF_FFFF, "R2"); rd(8'h00, "R2");
    wr(8'h00, 32'h0, "R2"); rd(8'h00, "R2");

    // R3, R5, R6: countdown, reload, interrupt
    wr(8'h08, 32'd3, "R4"); rd(8'h08, "R4");
    wr(8'h04, 32'd5, "R4"); rd(8'h04, "R3"); rd(8'h04, "R3");
    wr(8'h00, 32'h9, "R2");
    for (int i = 0; i < 12; i++) rd((i % 2) ? 8'h0C : 8'h04, "R5");
    wr(8'h0C, 32'h1, "R7"); rd(8'h0C, "R7"); rd(8'h0C, "R6");

    // R4: direct load while running
    wr(8'h04, 32'd40, "R4"); rd(8'h04, "R4"); rd(8'h04, "R4");

    // R8: clear coincides with zero reach
    wr(8'h00, 32'h1, "R8"); wr(8'h04, 32'd100, "R8");
    wr(8'h0C, 32'h1, "R8"); rd(8'h0C, "R8");
    wr(8'h04, 32'd0, "R8");
    wr(8'h0C, 32'h1, "R8");
    rd(8'h0C, "R8"); rd(8'h0C, "R8");
    wr(8'h0C, 32'h0, "R7"); rd(8'h0C, "R7");

    // R9: unmapped offsets
    wr(8'h00, 32'h0, "R9");
    wr(8'h10, 32'hDEAD_BEEF, "R9"); wr(8'h05, 32'h1234_5678, "R9"); wr(8'hFC, 32'hFFFF_FFFF, "R9");
    rd(8'h10, "R9"); rd(8'h05, "R9"); rd(8'h00, "R9"); rd(8'h04, "R9"); rd(8'h08, "R9"); rd(8'h0C, "R9");

    // R10: free-running wrap without interrupt
    wr(8'h0C, 32'h1, "R10");
    wr(8'h08, 32'hFFFF_FFFF, "R10"); wr(8'h04, 32'd2, "R10");
    wr(8'h00, 32'h1, "R10");
    for (int i = 0; i < 8; i++) rd(8'h04, "R10");
    rd(8'h0C, "R10"); rd(8'h0C, "R10");

    // R11 is implied by every cycle-aligned read check; random mix
    for (int i = 0; i < 3000; i++) begin
      int sel;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      sel = $urandom_range(0, 15);
      case ($urandom_range(0, 4))
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
        default: a = 8'($urandom_range(0, 255));
      endcase
      d = (a == 8'h00 || a == 8'h0C) ? $urandom() : 32'($urandom_range(0, 12));
      if (sel < 4) wr(a, d, "");
      else rd(a, (i % 97 == 0) ? "R11" : "");
    end
    rd(8'h00, "");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule